// File: doc/BRIEF.md
# Timestamp Record FIFO with Word-Serial Readout

This block buffers timestamp records captured for one port and one traffic direction, and hands them to a processor one 16-bit word at a time. A capture strobe delivers a complete record in a single cycle. The record holds a tag, a 48-bit seconds value, a 32-bit nanoseconds value, a 64-bit clock identity, a port number and a sequence id. The record is written into a first-in first-out store. Software pulls the oldest record out through a single data register, using twelve consecutive reads.

A status register exposes three items. The first is the capture enable. The second is a read-position counter, which shows software whether its next read starts a new record. The third is a saturating count of captures lost because the store was full. A non-empty flag and a masked interrupt output let a neighbouring aggregator collect the flags of several ports into one word. The capture side and the register side share one clock.

The readout is sequenced by a small state machine with three states. In WAIT_REC the position is 0 and the next read returns a tag. In STREAM the position is 1 to 10. In LAST the position is 11. The state machine has four transitions:
- TAKE_HEAD goes from WAIT_REC to STREAM on a read while data is present.
- ADVANCE stays in STREAM on a read at positions 1 to 9.
- TO_LAST goes from STREAM to LAST on a read at position 10.
- POP_REC goes from LAST to WAIT_REC on a read, and it removes the record from the store.

Top module: `stamp_record_fifo`

## Requirements
- R1: A record is read as 12 consecutive reads of `data_rdata`, each advanced by a `data_rd` pulse. The order is: tag, seconds (3 words), nanoseconds (2 words), clock identity (4 words), port number, sequence id. Every multi-word field comes most significant word first, and the tag is returned unchanged, including its low 3 message-type bits.
- R2: Status bits 12:8 hold the read position. The position is 0 when the next read returns a tag. Each read of a non-empty store increments it. After the 12th read it returns to 0 and the record is removed.
- R3: Status bit 15 is the capture enable. A status write loads it from `stat_wdata[15]`. While the enable is clear, capture strobes have no effect on the store or on the discarded count.
- R4: A capture strobe is dropped when it arrives while enabled and the store is full in that cycle. Each dropped strobe increments status bits 7:4, and the count saturates at 15. Any status write clears the count.
- R5: The store holds DEPTH records (default 96, never fewer than 90). Records are read back in the order they were captured.
- R6: A data read while the store is empty returns 0 and leaves the read position unchanged.
- R7: `not_empty` is 1 exactly when at least one record is stored. `irq` is `not_empty` gated by `irq_mask`.
- R8: After reset the status register reads 0x0000, the store is empty, `data_rdata` is 0 and `irq` is 0. Status bits 14:13 and 3:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | 1 | Capture strobe, one record per cycle |
| cap_tag | input | 16 | Record tag, message type in bits 2:0 |
| cap_sec | input | 48 | Seconds |
| cap_nsec | input | 32 | Nanoseconds |
| cap_clkid | input | 64 | Clock identity |
| cap_portnum | input | 16 | Port number |
| cap_seqid | input | 16 | Sequence id |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 16 | Status write data, bit 15 is the enable |
| stat_rdata | output | 16 | Status: enable, read position, discarded count |
| data_rd | input | 1 | Data register read strobe |
| data_rdata | output | 16 | Current record word, or 0 when empty |
| irq_mask | input | 1 | Interrupt mask bit |
| not_empty | output | 1 | Store holds a record |
| irq | output | 1 | Masked non-empty interrupt |

## Verification
The bench uses records whose twelve words are distinct functions of the record index. The first pattern is a single record read word by word, with the position checked after each read; this separates a correct field order from swapped fields, and most-significant-word-first delivery from word reversal. The second pattern fills the store to its full depth and then sends twenty further strobes. Draining the store afterwards checks the capture order, and it shows that the extra strobes were dropped rather than overwriting records. The discarded count is checked after one drop and again after it saturates. Strobes sent while disabled, reads of an empty store, and toggling of the mask each test one gating path on its own.

// File: rtl/srf_pkg.sv
package srf_pkg;
    localparam int WORD_W = 16;
    localparam int TAG_W  = 16;
    localparam int SEC_W  = 48;
    localparam int NSEC_W = 32;
    localparam int CLK_W  = 64;
    localparam int PORT_W = 16;
    localparam int SEQ_W  = 16;
    localparam int REC_W  = TAG_W + SEC_W + NSEC_W + CLK_W + PORT_W + SEQ_W;
    localparam int WORDS  = REC_W / WORD_W;
    localparam int POS_W  = 5;
    localparam int DISC_W = 4;

    // Field order from MSB down is the readout order.
    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [SEC_W-1:0]  sec;
        logic [NSEC_W-1:0] nsec;
        logic [CLK_W-1:0]  clkid;
        logic [PORT_W-1:0] portnum;
        logic [SEQ_W-1:0]  seqid;
    } rec_t;

    typedef enum logic [1:0] {
        WAIT_REC = 2'd0,
        STREAM   = 2'd1,
        LAST     = 2'd2
    } rd_state_t;
endpackage

// File: rtl/srf_store.sv
module srf_store
    import srf_pkg::*;
#(
    parameter int DEPTH = 96
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  rec_t push_rec,
    input  logic pop,
    output rec_t head_rec,
    output logic full,
    output logic empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    rec_t             mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign head_rec = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_rec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/srf_serializer.sv
module srf_serializer
    import srf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              empty,
    input  rec_t              head_rec,
    output logic [WORD_W-1:0] word,
    output logic [POS_W-1:0]  pos,
    output logic              pop
);
    rd_state_t        state;
    rd_state_t        state_nx;
    logic [POS_W-1:0] pos_nx;
    logic [WORD_W-1:0] words [WORDS];
    logic [REC_W-1:0]  flat;

    assign flat = head_rec;

    for (genvar g = 0; g < WORDS; g++) begin : g_slice
        assign words[g] = flat[REC_W-1-g*WORD_W -: WORD_W];
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WAIT_REC;
            pos   <= '0;
        end else begin
            state <= state_nx;
            pos   <= pos_nx;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx = state;
        pos_nx   = pos;
        pop      = 1'b0;
        word     = '0;
        if (!empty && pos < POS_W'(WORDS)) begin
            word = words[pos[3:0]];
        end
        unique case (state)
            WAIT_REC: begin
                if (rd && !empty) begin
                    state_nx = STREAM;
                    pos_nx   = POS_W'(1);
                end
            end
            STREAM: begin
                if (rd) begin
                    pos_nx = pos + 1'b1;
                    if (pos == POS_W'(WORDS - 2)) begin
                        state_nx = LAST;
                    end
                end
            end
            LAST: begin
                if (rd) begin
                    state_nx = WAIT_REC;
                    pos_nx   = '0;
                    pop      = 1'b1;
                end
            end
            default: begin
                state_nx = WAIT_REC;
                pos_nx   = '0;
            end
        endcase
    end
endmodule

// File: rtl/srf_ctrl.sv
module srf_ctrl
    import srf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic [WORD_W-1:0] stat_wdata,
    input  logic              drop,
    output logic              enable,
    output logic [DISC_W-1:0] disc
);
    localparam logic [DISC_W-1:0] DISC_MAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
            disc   <= '0;
        end else if (stat_wr) begin
            enable <= stat_wdata[15];
            disc   <= '0;
        end else if (drop && disc != DISC_MAX) begin
            disc <= disc + 1'b1;
        end
    end
endmodule

// File: rtl/stamp_record_fifo.sv
module stamp_record_fifo
    import srf_pkg::*;
#(
    parameter int DEPTH = 96
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cap_valid,
    input  logic [15:0] cap_tag,
    input  logic [47:0] cap_sec,
    input  logic [31:0] cap_nsec,
    input  logic [63:0] cap_clkid,
    input  logic [15:0] cap_portnum,
    input  logic [15:0] cap_seqid,
    input  logic        stat_wr,
    input  logic [15:0] stat_wdata,
    output logic [15:0] stat_rdata,
    input  logic        data_rd,
    output logic [15:0] data_rdata,
    input  logic        irq_mask,
    output logic        not_empty,
    output logic        irq
);
    rec_t              cap_rec;
    rec_t              head_rec;
    logic              full;
    logic              empty;
    logic              enable;
    logic              push;
    logic              drop;
    logic              pop;
    logic [POS_W-1:0]  pos;
    logic [DISC_W-1:0] disc;

    assign cap_rec = '{tag: cap_tag, sec: cap_sec, nsec: cap_nsec,
                       clkid: cap_clkid, portnum: cap_portnum, seqid: cap_seqid};
    assign push = cap_valid && enable;
    assign drop = push && full;

    srf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .push_rec(cap_rec),
        .pop(pop), .head_rec(head_rec), .full(full), .empty(empty)
    );

    srf_serializer u_ser (
        .clk(clk), .rst_n(rst_n), .rd(data_rd), .empty(empty),
        .head_rec(head_rec), .word(data_rdata), .pos(pos), .pop(pop)
    );

    srf_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .drop(drop), .enable(enable), .disc(disc)
    );

    assign stat_rdata = {enable, 2'b00, pos, disc, 4'b0000};
    assign not_empty  = !empty;
    assign irq        = not_empty && irq_mask;
endmodule

// File: rtl/srf_checker.sv
module srf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        data_rd,
    input logic        stat_wr,
    input logic        cap_valid,
    input logic        not_empty,
    input logic [15:0] stat_rdata,
    input logic [15:0] data_rdata
);
    // R2: position never leaves the record
    p_pos_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[12:8] <= 5'd11);

    // R2: last word read wraps the position
    p_pos_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && stat_rdata[12:8] == 5'd11) |=> stat_rdata[12:8] == 5'd0);

    // R6: empty read does not advance
    p_empty_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!not_empty && data_rd) |=> $stable(stat_rdata[12:8]));

    // R6: empty store reads zero
    p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !not_empty |-> data_rdata == 16'h0000);

    // R4: saturation holds without a status write
    p_disc_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdata[7:4] == 4'hF && !stat_wr) |=> stat_rdata[7:4] == 4'hF);

    // R3: disabled captures do not fill the store
    p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_rdata[15] && !stat_wr && !not_empty) |=> !not_empty);

    // R8: reserved status bits read 0
    p_rsvd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rdata[14:13] == 2'b00 && stat_rdata[3:0] == 4'h0);
endmodule

bind stamp_record_fifo srf_checker u_chk (
    .clk(clk), .rst_n(rst_n), .data_rd(data_rd), .stat_wr(stat_wr),
    .cap_valid(cap_valid), .not_empty(not_empty),
    .stat_rdata(stat_rdata), .data_rdata(data_rdata)
);

// File: tb/stamp_record_fifo_test.sv
module stamp_record_fifo_test;
    localparam int DEPTH = 96;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_valid = 1'b0;
    logic [15:0] cap_tag = '0;
    logic [47:0] cap_sec = '0;
    logic [31:0] cap_nsec = '0;
    logic [63:0] cap_clkid = '0;
    logic [15:0] cap_portnum = '0;
    logic [15:0] cap_seqid = '0;
    logic        stat_wr = 1'b0;
    logic [15:0] stat_wdata = '0;
    logic [15:0] stat_rdata;
    logic        data_rd = 1'b0;
    logic [15:0] data_rdata;
    logic        irq_mask = 1'b0;
    logic        not_empty;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    stamp_record_fifo #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_tag(cap_tag),
        .cap_sec(cap_sec), .cap_nsec(cap_nsec), .cap_clkid(cap_clkid),
        .cap_portnum(cap_portnum), .cap_seqid(cap_seqid), .stat_wr(stat_wr),
        .stat_wdata(stat_wdata), .stat_rdata(stat_rdata), .data_rd(data_rd),
        .data_rdata(data_rdata), .irq_mask(irq_mask), .not_empty(not_empty),
        .irq(irq)
    );

    function automatic logic [191:0] rec_vec(input int i);
        logic [15:0] tag;
        logic [47:0] sec;
        logic [31:0] ns;
        logic [63:0] ck;
        tag = {13'(i * 3), 3'((i % 4) + 1)};
        sec = {16'(i), 16'hC0DE ^ 16'(i), 16'(i * 7)};
        ns  = {16'(i + 1), ~16'(i)};
        ck  = {16'(i * 11), 16'hFACE, 16'(i + 9), 16'(i * 5 + 3)};
        return {tag, sec, ns, ck, 16'(i * 13 + 1), 16'hFFFF - 16'(i)};
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic capture(input int i);
        logic [191:0] v;
        v = rec_vec(i);
        @(negedge clk);
        {cap_tag, cap_sec, cap_nsec, cap_clkid, cap_portnum, cap_seqid} = v;
        cap_valid = 1'b1;
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    task automatic stat_write(input logic [15:0] d);
        @(negedge clk);
        stat_wr = 1'b1;
        stat_wdata = d;
        @(negedge clk);
        stat_wr = 1'b0;
    endtask

    // Reads a whole record; checks every word and, if full_chk, every position.
    task automatic read_record(input int i, input bit full_chk);
        logic [191:0] v;
        v = rec_vec(i);
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (full_chk || data_rdata !== v[191 - 16 * k -: 16])
                check({16'h0, data_rdata}, {16'h0, v[191 - 16 * k -: 16]},
                      $sformatf("R1 rec %0d word %0d", i, k));
            data_rd = 1'b1;
            @(negedge clk);
            data_rd = 1'b0;
            if (full_chk || stat_rdata[12:8] !== 5'((k + 1) % 12))
                check({27'h0, stat_rdata[12:8]}, 32'((k + 1) % 12),
                      $sformatf("R2 rec %0d pos after word %0d", i, k));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({16'h0, stat_rdata}, 32'h0, "R8 reset status");
        check({31'h0, not_empty}, 32'h0, "R8 reset empty");
        check({16'h0, data_rdata}, 32'h0, "R8 reset data");
        check({31'h0, irq}, 32'h0, "R8 reset irq");

        // R3: disabled capture ignored
        capture(0);
        @(negedge clk);
        check({31'h0, not_empty}, 32'h0, "R3 disabled capture ignored");
        check({16'h0, stat_rdata}, 32'h0, "R3 disabled no discard");

        stat_write(16'h8000);
        check({31'h0, stat_rdata[15]}, 32'h1, "R3 enable set");

        // R6: empty read
        @(negedge clk);
        data_rd = 1'b1;
        @(negedge clk);
        data_rd = 1'b0;
        check({27'h0, stat_rdata[12:8]}, 32'h0, "R6 empty read no advance");
        check({16'h0, data_rdata}, 32'h0, "R6 empty read zero");

        // R1/R2/R7: single record
        capture(5);
        check({31'h0, not_empty}, 32'h1, "R7 not_empty after capture");
        check({31'h0, irq}, 32'h0, "R7 irq masked");
        irq_mask = 1'b1;
        #1;
        check({31'h0, irq}, 32'h1, "R7 irq unmasked");
        read_record(5, 1'b1);
        check({31'h0, not_empty}, 32'h0, "R2 popped after 12th word");
        check({31'h0, irq}, 32'h0, "R7 irq cleared when empty");

        // R5/R4: fill and overflow
        for (int i = 0; i < DEPTH; i++) capture(i + 10);
        check({28'h0, stat_rdata[7:4]}, 32'h0, "R5 full depth no drop");
        capture(500);
        check({28'h0, stat_rdata[7:4]}, 32'h1, "R4 first drop counted");
        for (int i = 0; i < 19; i++) capture(600 + i);
        check({28'h0, stat_rdata[7:4]}, 32'hF, "R4 count saturates");
        stat_write(16'h8000);
        check({28'h0, stat_rdata[7:4]}, 32'h0, "R4 write clears count");
        check({31'h0, stat_rdata[15]}, 32'h1, "R3 enable kept by write");
        for (int i = 0; i < DEPTH; i++) begin
            check({31'h0, not_empty}, 32'h1, $sformatf("R5 record %0d present", i));
            read_record(i + 10, 1'b0);
        end
        check({31'h0, not_empty}, 32'h0, "R5 drained, drops not stored");

        // R3: disable again
        stat_write(16'h0000);
        capture(7);
        @(negedge clk);
        check({31'h0, not_empty}, 32'h0, "R3 capture ignored after disable");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule